// File: doc/BRIEF.md
# Triggered SPI Command Replay Offload

This block keeps a short SPI transfer program in two local memories, one holding command words and one holding serial output data words. A control port fills each memory through a write strobe. Each memory has its own write pointer that steps forward on every accepted write, and a single clear input empties both memories. Once the program is loaded, raising `arm` lets the block respond to an external trigger. On each trigger it plays the whole program to a downstream SPI execution engine.

A replay offers the stored command words in address order on one valid/ready stream and the stored data words on a second, independent stream. The replay finishes only when every command has been taken and the engine returns a completion pulse. The `armed` status output stays high from the moment `arm` rises until any replay already in flight has finished. While `armed` is high, the memories cannot be changed.

Top module: `spi_replay_offload`

## Requirements
- R1: Each cycle with `cmd_we` high, and writes permitted, stores `cmd_wdata` at the command write pointer and advances that pointer by one, starting from address 0.
- R2: The data memory is filled the same way through `dat_we`/`dat_wdata`, using a pointer independent of the command pointer.
- R3: A permitted `mem_clr` pulse zeroes both memories, both write pointers and the overflow flag. A replay after a clear streams only the entries written since the clear.
- R4: With `arm` high and no replay running, a rising edge on `trig_in` starts a replay. The first valid appears within 10 cycles of the edge.
- R5: With `arm` low, a trigger starts nothing. Dropping `arm` during a replay lets that replay run to its end.
- R6: `armed` is high whenever `arm` is high, and also while a replay is in progress. It is low otherwise.
- R7: While `armed` is high, `cmd_we`, `dat_we` and `mem_clr` have no effect.
- R8: A replay presents command entries 0 to (count-1) on `cmd_data` with `cmd_valid`, one per `cmd_valid && cmd_ready` cycle. An offered word stays stable until it is taken. The data memory streams the same way on `dat_*`.
- R9: A `xfer_done` pulse ends the replay only in a cycle where all commands have already been taken, meaning `cmd_valid` is low. Earlier pulses are ignored.
- R10: A write to a memory that already holds DEPTH (default 16) entries is dropped, and it sets the sticky `wr_ovf` flag. Only a permitted clear resets that flag.
- R11: A trigger edge that arrives while a replay is running is dropped, not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command memory write strobe |
| cmd_wdata | input | CMD_W | Command word to store |
| dat_we | input | 1 | Data memory write strobe |
| dat_wdata | input | DAT_W | Data word to store |
| mem_clr | input | 1 | Clear both memories and pointers |
| arm | input | 1 | Allow triggers to start a replay |
| armed | output | 1 | Armed or replay still running |
| trig_in | input | 1 | Asynchronous external trigger |
| cmd_valid | output | 1 | Command word offered |
| cmd_ready | input | 1 | Engine takes the command word |
| cmd_data | output | CMD_W | Offered command word |
| dat_valid | output | 1 | Data word offered |
| dat_ready | input | 1 | Engine takes the data word |
| dat_data | output | DAT_W | Offered data word |
| xfer_done | input | 1 | Engine completion pulse |
| wr_ovf | output | 1 | Sticky write overflow flag |

## Verification
Several events can land in the same cycle. A completion pulse can coincide with the last command hand-off. A trigger edge can arrive while a replay is running. A write or clear can be requested on a cycle where `arm` is high. The bench raises `xfer_done` while a command is still outstanding and expects `armed` to stay high afterwards. It pulses the trigger in the middle of a replay and expects no second stream. It attempts writes and a clear while armed, then judges the result from the replay length and the overflow flag.

// File: rtl/spi_replay_pkg.sv
package spi_replay_pkg;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_RUN  = 1'b1
    } replay_state_e;

    typedef struct packed {
        logic we;
        logic clr;
    } wr_ctl_t;

    function automatic logic gate_write(input logic req, input logic locked);
        return req & ~locked;
    endfunction

endpackage

// File: rtl/replay_mem.sv
module replay_mem #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  spi_replay_pkg::wr_ctl_t  ctl,
    input  logic [W-1:0]             wdata,
    input  logic [AW-1:0]            rd_addr,
    output logic [W-1:0]             rd_data,
    output logic [CW-1:0]            count,
    output logic                     ovf
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else if (ctl.we) begin
            if (count == FULL) begin
                ovf <= 1'b1;
            end else begin
                store[count[AW-1:0]] <= wdata;
                count <= count + 1'b1;
            end
        end
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/trig_edge.sv
module trig_edge (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [2:0] shr;

    always_ff @(posedge clk) begin
        if (rst) shr <= '0;
        else     shr <= {shr[1:0], async_in};
    end

    assign rise = shr[1] & ~shr[2];
endmodule

// File: rtl/replay_seq.sv
module replay_seq #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] cmd_cnt,
    input  logic [CW-1:0] dat_cnt,
    input  logic          cmd_ready,
    input  logic          dat_ready,
    input  logic          done,
    output logic          busy,
    output logic          cmd_valid,
    output logic          dat_valid,
    output logic [CW-1:0] cmd_ptr,
    output logic [CW-1:0] dat_ptr
);
    import spi_replay_pkg::*;

    replay_state_e state;
    logic          cmds_drained;

    assign busy         = (state == RS_RUN);
    assign cmd_valid    = busy && (cmd_ptr < cmd_cnt);
    assign dat_valid    = busy && (dat_ptr < dat_cnt);
    assign cmds_drained = (cmd_ptr == cmd_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RS_IDLE;
            cmd_ptr <= '0;
            dat_ptr <= '0;
        end else begin
            case (state)
                RS_IDLE: begin
                    if (start) begin
                        state   <= RS_RUN;
                        cmd_ptr <= '0;
                        dat_ptr <= '0;
                    end
                end
                default: begin
                    if (cmd_valid && cmd_ready) cmd_ptr <= cmd_ptr + 1'b1;
                    if (dat_valid && dat_ready) dat_ptr <= dat_ptr + 1'b1;
                    if (cmds_drained && done)   state   <= RS_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_replay_offload.sv
module spi_replay_offload #(
    parameter int CMD_W = 16,
    parameter int DAT_W = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             dat_we,
    input  logic [DAT_W-1:0] dat_wdata,
    input  logic             mem_clr,
    input  logic             arm,
    output logic             armed,
    input  logic             trig_in,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [CMD_W-1:0] cmd_data,
    output logic             dat_valid,
    input  logic             dat_ready,
    output logic [DAT_W-1:0] dat_data,
    input  logic             xfer_done,
    output logic             wr_ovf
);
    import spi_replay_pkg::*;

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic          busy;
    logic          trig_rise;
    logic [CW-1:0] cmd_cnt, dat_cnt, cmd_ptr, dat_ptr;
    logic          cmd_ovf, dat_ovf;
    wr_ctl_t       cmd_ctl, dat_ctl;

    assign armed = arm | busy;

    assign cmd_ctl.we  = gate_write(cmd_we, armed);
    assign cmd_ctl.clr = gate_write(mem_clr, armed);
    assign dat_ctl.we  = gate_write(dat_we, armed);
    assign dat_ctl.clr = gate_write(mem_clr, armed);

    replay_mem #(.W(CMD_W), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_cmd_mem (
        .clk(clk), .rst(rst), .ctl(cmd_ctl), .wdata(cmd_wdata),
        .rd_addr(cmd_ptr[AW-1:0]), .rd_data(cmd_data),
        .count(cmd_cnt), .ovf(cmd_ovf)
    );

    replay_mem #(.W(DAT_W), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_dat_mem (
        .clk(clk), .rst(rst), .ctl(dat_ctl), .wdata(dat_wdata),
        .rd_addr(dat_ptr[AW-1:0]), .rd_data(dat_data),
        .count(dat_cnt), .ovf(dat_ovf)
    );

    trig_edge u_trig (
        .clk(clk), .rst(rst), .async_in(trig_in), .rise(trig_rise)
    );

    replay_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst(rst),
        .start(trig_rise & arm & ~busy),
        .cmd_cnt(cmd_cnt), .dat_cnt(dat_cnt),
        .cmd_ready(cmd_ready), .dat_ready(dat_ready),
        .done(xfer_done), .busy(busy),
        .cmd_valid(cmd_valid), .dat_valid(dat_valid),
        .cmd_ptr(cmd_ptr), .dat_ptr(dat_ptr)
    );

    assign wr_ovf = cmd_ovf | dat_ovf;
endmodule

// File: rtl/spi_replay_offload_chk.sv
module spi_replay_offload_chk #(
    parameter int CMD_W = 16,
    parameter int CW    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             arm,
    input logic             armed,
    input logic             busy,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [CMD_W-1:0] cmd_data,
    input logic [CW-1:0]    cmd_cnt,
    input logic [CW-1:0]    dat_cnt,
    input logic             xfer_done,
    input logic             mem_clr,
    input logic             wr_ovf
);
    a_r6_arm_sets_armed: assert property (@(posedge clk) disable iff (rst)
        arm |-> armed);

    a_r7_counts_frozen: assert property (@(posedge clk) disable iff (rst)
        armed |=> ($stable(cmd_cnt) && $stable(dat_cnt)));

    a_r8_cmd_held: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

    a_r9_end_needs_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(xfer_done));

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (wr_ovf && !(mem_clr && !armed)) |=> wr_ovf);

    a_r11_valid_in_replay: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> busy);
endmodule

bind spi_replay_offload spi_replay_offload_chk #(.CMD_W(CMD_W), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .arm(arm), .armed(armed), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_cnt(cmd_cnt), .dat_cnt(dat_cnt), .xfer_done(xfer_done),
    .mem_clr(mem_clr), .wr_ovf(wr_ovf)
);

// File: tb/spi_replay_offload_tb.sv
`timescale 1ns/1ps
module spi_replay_offload_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 0, dat_we = 0, mem_clr = 0, arm = 0, trig_in = 0;
    logic [15:0] cmd_wdata = '0;
    logic [7:0]  dat_wdata = '0;
    logic        cmd_ready = 0, dat_ready = 0, xfer_done = 0;
    logic        armed, cmd_valid, dat_valid, wr_ovf;
    logic [15:0] cmd_data;
    logic [7:0]  dat_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [15:0] exp_cmd [20];
    logic [7:0]  exp_dat [20];

    // {command word, data word}
    localparam logic [23:0] VEC [4] = '{
        24'hA001_11, 24'h5A5A_22, 24'hFFFF_33, 24'h0000_44
    };

    always #2.5 clk = ~clk;

    spi_replay_offload u_dut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .mem_clr(mem_clr),
        .arm(arm), .armed(armed), .trig_in(trig_in),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data),
        .xfer_done(xfer_done), .wr_ovf(wr_ovf)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_cmd(input logic [15:0] v);
        cmd_we = 1; cmd_wdata = v; tick(); cmd_we = 0;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        dat_we = 1; dat_wdata = v; tick(); dat_we = 0;
    endtask

    task automatic pulse_clr();
        mem_clr = 1; tick(); mem_clr = 0;
    endtask

    task automatic quiet(input string req);
        bit seen = 0;
        for (int k = 0; k < 10; k++) begin
            #1; if (cmd_valid || dat_valid) seen = 1; tick();
        end
        chk(!seen, req, seen, 0);
    endtask

    task automatic replay(input int ncmd, input int ndat, input bit drop_arm, input bit mid_trig);
        int ci = 0, di = 0, w = 0;
        arm = 1; trig_in = 1; tick(); tick(); trig_in = 0;
        while (!cmd_valid && !dat_valid && w < 10) begin tick(); w++; end
        chk(w < 10, "R4 replay start", w, 10);
        for (int cyc = 0; cyc < 60; cyc++) begin
            cmd_ready = cyc[0];
            dat_ready = (cyc % 3 != 0);
            xfer_done = (cyc == 1);               // R9: early done, must be ignored
            if (mid_trig && cyc == 4) trig_in = 1;  // R11: trigger during replay
            if (mid_trig && cyc == 7) trig_in = 0;
            if (drop_arm && cyc == 3) arm = 0;      // R5: run continues
            #1;
            if (cmd_valid && cmd_ready) begin
                chk(ci < ncmd && cmd_data == exp_cmd[ci], "R1/R8 command order", cmd_data, exp_cmd[ci]);
                ci++;
            end
            if (dat_valid && dat_ready) begin
                chk(di < ndat && dat_data == exp_dat[di], "R2/R8 data order", dat_data, exp_dat[di]);
                di++;
            end
            tick();
            xfer_done = 0;
        end
        cmd_ready = 0; dat_ready = 0;
        chk(ci == ncmd, "R8 command count", ci, ncmd);
        chk(di == ndat, "R2 data count", di, ndat);
        chk(armed == 1'b1, "R9 early done ignored / R6 armed while busy", armed, 1);
        xfer_done = 1; tick(); xfer_done = 0;
        chk(armed == arm, "R9 done ends replay / R5", armed, arm);
        arm = 0; tick();
        chk(armed == 1'b0, "R6 armed low when idle", armed, 0);
        if (mid_trig) quiet("R11 trigger dropped");
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0; tick();
        chk(armed == 0, "R6 reset armed", armed, 0);
        chk(cmd_valid == 0 && dat_valid == 0, "R8 reset valids", {cmd_valid, dat_valid}, 0);
        chk(wr_ovf == 0, "R10 reset ovf", wr_ovf, 0);

        // load table: 4 commands, 3 data words
        foreach (VEC[i]) begin
            wr_cmd(VEC[i][23:8]); exp_cmd[i] = VEC[i][23:8];
            if (i < 3) begin wr_dat(VEC[i][7:0]); exp_dat[i] = VEC[i][7:0]; end
        end

        // R7: write while armed is ignored
        arm = 1; tick();
        chk(armed == 1, "R6 arm drives armed", armed, 1);
        wr_cmd(16'hDEAD); wr_dat(8'hEE);

        replay(4, 3, 0, 1);
        replay(4, 3, 1, 0);

        // R5: trigger with arm low
        trig_in = 1; tick(); tick(); trig_in = 0;
        quiet("R5 disarmed trigger ignored");

        // R10: overflow
        pulse_clr();
        for (int i = 0; i < 16; i++) begin wr_cmd(16'(i)); exp_cmd[i] = 16'(i); end
        chk(wr_ovf == 0, "R10 full without overflow", wr_ovf, 0);
        wr_cmd(16'h1234);
        chk(wr_ovf == 1, "R10 overflow set", wr_ovf, 1);
        tick();
        chk(wr_ovf == 1, "R10 overflow sticky", wr_ovf, 1);
        replay(16, 0, 0, 0);

        // R7: clear while armed is ignored
        arm = 1; tick(); pulse_clr(); arm = 0; tick();
        chk(wr_ovf == 1, "R7 clear ignored while armed", wr_ovf, 1);

        // R3: clear then a single entry
        pulse_clr();
        chk(wr_ovf == 0, "R3 clear resets overflow", wr_ovf, 0);
        wr_cmd(16'hBEEF); exp_cmd[0] = 16'hBEEF;
        replay(1, 0, 0, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule